// File: doc/BRIEF.md
# Goldschmidt Fixed-Point Divider

This block divides one unsigned fixed-point fraction by another. It does not produce one quotient bit per cycle. It scales the numerator and the denominator by the same correction factor again and again, until the denominator is close enough to one that the numerator is the quotient. A small table, computed at elaboration and addressed by the divisor bits just below its leading one, provides the first factor. Each later factor is the two's complement of the current denominator, that is 2 − B. Every product is truncated back to a datapath that has one integer bit, the operand fraction bits and a few guard bits.

The caller normalises the divisor so that its top bit is set, which puts it in [1/2, 1). The caller shifts the dividend by the same amount. The caller then pulses `start` for one cycle. When the loop ends, `done` is high for one cycle and `quotient` holds the result until the next result replaces it. A `start` pulse that arrives while a division is in progress is ignored. A parameter selects between two variants. One uses two multipliers and completes an iteration in every cycle. The other shares one multiplier and takes two cycles per iteration.

Top module: `gs_divider`

## Requirements
- R1: While the active-low asynchronous reset `rst_n` is low, `done` is low and `quotient` is zero.
- R2: `dividend` and `divisor` are 16-bit unsigned fractions whose value is the code divided by 65536, and bit 15 of `divisor` must be set. `quotient` is 17 bits wide: bit 16 is the integer bit and its value is the code divided by 65536. A completed result is within one code of floor(dividend·65536/divisor).
- R3: A zero dividend yields a quotient of exactly zero.
- R4: The largest ratio (dividend 0xFFFF, divisor 0x8000, exact code 0x1FFFE) yields a quotient from 0x1FFFD to 0x1FFFF. The integer bit does not wrap.
- R5: Each accepted `start` produces exactly one `done`, and `done` is high for exactly one cycle.
- R6: The loop stops once the denominator is within one guard LSB of 1.0, or after the elaboration-derived step limit. With the defaults, `done` is seen no later than the 5th rising edge after the edge that samples `start` in the two-multiplier variant, and no later than the 9th in the shared-multiplier variant.
- R7: A `start` pulse while a division is in progress does not change that division's result and does not produce a second `done`.
- R8: `quotient` changes only in the cycle in which `done` is high. Between completions it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a division; ignored while busy |
| dividend | input | FRAC_W | Numerator fraction, pre-shifted to match the divisor |
| divisor | input | FRAC_W | Normalised denominator fraction, top bit set |
| quotient | output | FRAC_W+1 | Result, one integer bit over FRAC_W fraction bits |
| done | output | 1 | One-cycle pulse when `quotient` is updated |

## Verification
The bench builds two instances side by side. Both use 16 fraction bits, 4 guard bits and a 3-bit seed index. One sets PAR_MUL to 1 and the other sets it to 0, so both generate branches are driven by the same stimulus. These values give a 21-bit datapath and a limit of four multiply steps. That limit lets each variant's latency bound be checked exactly, and the ±1 code accuracy to be checked at the extremes of the divisor range, including the ratio that sits just under the integer bit's overflow. A second `start` is issued in the middle of a run to show that both controllers ignore it, whether the run is in a single-cycle step or in a two-phase step.

// File: rtl/gs_div_pkg.sv
package gs_div_pkg;

   typedef enum logic {
      GS_IDLE = 1'b0,
      GS_RUN  = 1'b1
   } gs_state_e;

   // Multiply steps needed: the seed step gives seed_w+1 correct bits,
   // and every later step doubles the count, until frac_total+1 is reached.
   function automatic int step_count(input int seed_w, input int frac_total);
      int acc;
      int n;
      acc = seed_w + 1;
      n   = 1;
      while (acc < frac_total + 1) begin
         acc = acc * 2;
         n   = n + 1;
      end
      return n;
   endfunction

   // Seed factor for table slot idx: the reciprocal of the slot's midpoint
   // divisor, as an unsigned value with frac_total fraction bits.
   function automatic logic [63:0] seed_val(input int idx, input int seed_w,
                                            input int frac_total);
      logic [63:0] num;
      logic [63:0] den;
      num = 64'd1 << (frac_total + seed_w + 2);
      den = (64'd1 << (seed_w + 1)) + 64'(2 * idx + 1);
      return num / den;
   endfunction

endpackage

// File: rtl/gs_seed_rom.sv
module gs_seed_rom #(
   parameter int SEED_W = 3,
   parameter int FT     = 20
) (
   input  logic [SEED_W-1:0] idx,
   output logic [FT:0]       f0
);
   localparam int N     = FT + 1;
   localparam int DEPTH = 1 << SEED_W;

   logic [N-1:0] tbl [DEPTH];

   for (genvar k = 0; k < DEPTH; k++) begin : g_ent
      assign tbl[k] = N'(gs_div_pkg::seed_val(k, SEED_W, FT));
   end

   assign f0 = tbl[idx];
endmodule

// File: rtl/gs_fx_mul.sv
module gs_fx_mul #(
   parameter int FT = 20
) (
   input  logic [FT:0] x,
   input  logic [FT:0] y,
   output logic [FT:0] p
);
   localparam int N = FT + 1;

   logic [2*N-1:0] full;

   assign full = {{N{1'b0}}, x} * {{N{1'b0}}, y};
   // keep one integer bit and FT fraction bits, discard the rest (truncate)
   assign p    = N'(full >> FT);
endmodule

// File: rtl/gs_unity_det.sv
module gs_unity_det #(
   parameter int FT  = 20,
   parameter int TOL = 1
) (
   input  logic [FT:0] den,
   output logic        hit
);
   localparam int           N   = FT + 1;
   localparam logic [N-1:0] ONE = N'(1) << FT;
   localparam logic [N-1:0] LO  = ONE - N'(TOL);
   localparam logic [N-1:0] HI  = ONE + N'(TOL);

   assign hit = (den >= LO) && (den <= HI);
endmodule

// File: rtl/gs_divider.sv
module gs_divider #(
   parameter int FRAC_W  = 16,
   parameter int GUARD_W = 4,
   parameter int SEED_W  = 3,
   parameter int PAR_MUL = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [FRAC_W-1:0] dividend,
   input  logic [FRAC_W-1:0] divisor,
   output logic [FRAC_W:0]   quotient,
   output logic              done
);
   import gs_div_pkg::*;

   localparam int FT      = FRAC_W + GUARD_W;
   localparam int N       = FT + 1;
   localparam int QW      = FRAC_W + 1;
   localparam int STEPS   = step_count(SEED_W, FT);
   localparam int CNT_W   = $clog2(STEPS + 1);
   localparam int LAT_MAX = (PAR_MUL != 0) ? STEPS + 1 : 2 * STEPS + 1;

   if (FRAC_W < 4) begin : g_bad_frac
      $error("gs_divider: FRAC_W must be at least 4");
   end
   if (GUARD_W < 2) begin : g_bad_guard
      $error("gs_divider: GUARD_W must be at least 2");
   end
   if (SEED_W < 1 || SEED_W > FRAC_W - 1) begin : g_bad_seed
      $error("gs_divider: SEED_W must lie in 1..FRAC_W-1");
   end
   if (FT + SEED_W + 2 > 62) begin : g_bad_total
      $error("gs_divider: seed computation exceeds 64-bit range");
   end
   if (PAR_MUL != 0 && PAR_MUL != 1) begin : g_bad_par
      $error("gs_divider: PAR_MUL must be 0 or 1");
   end

   gs_state_e          state;
   logic [N-1:0]       a_r, b_r, f_r;
   logic [CNT_W-1:0]   cnt;
   logic               phase;
   logic               busy, conv, finish;
   logic [N-1:0]       a_init, b_init, seed_f;
   logic [N-1:0]       a_nx, b_nx, f_nx;
   logic               ph_nx, step_done;

   assign a_init = {1'b0, dividend, {GUARD_W{1'b0}}};
   assign b_init = {1'b0, divisor,  {GUARD_W{1'b0}}};

   gs_seed_rom #(.SEED_W(SEED_W), .FT(FT)) u_seed (
      .idx (divisor[FRAC_W-2 -: SEED_W]),
      .f0  (seed_f)
   );

   gs_unity_det #(.FT(FT), .TOL(1)) u_unity (
      .den (b_r),
      .hit (conv)
   );

   if (PAR_MUL != 0) begin : g_par
      logic [N-1:0] a_m, b_m;
      gs_fx_mul #(.FT(FT)) u_mul_num (.x(a_r), .y(f_r), .p(a_m));
      gs_fx_mul #(.FT(FT)) u_mul_den (.x(b_r), .y(f_r), .p(b_m));
      always_comb begin
         a_nx      = a_m;
         b_nx      = b_m;
         f_nx      = -b_m;       // next factor: 2 - B in two's complement
         ph_nx     = 1'b0;
         step_done = 1'b1;
      end
   end else begin : g_ser
      logic [N-1:0] op, m;
      assign op = phase ? a_r : b_r;
      gs_fx_mul #(.FT(FT)) u_mul_shr (.x(op), .y(f_r), .p(m));
      always_comb begin
         a_nx      = phase ? m : a_r;
         b_nx      = phase ? b_r : m;
         f_nx      = phase ? -b_r : f_r;
         ph_nx     = ~phase;
         step_done = phase;
      end
   end

   assign busy   = (state == GS_RUN);
   assign finish = busy && !phase && (conv || cnt == CNT_W'(STEPS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= GS_IDLE;
         a_r      <= '0;
         b_r      <= '0;
         f_r      <= '0;
         cnt      <= '0;
         phase    <= 1'b0;
         quotient <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (state == GS_IDLE) begin
            if (start) begin
               a_r   <= a_init;
               b_r   <= b_init;
               f_r   <= seed_f;
               cnt   <= '0;
               phase <= 1'b0;
               state <= GS_RUN;
            end
         end else if (finish) begin
            quotient <= QW'(a_r >> GUARD_W);
            done     <= 1'b1;
            state    <= GS_IDLE;
         end else begin
            a_r   <= a_nx;
            b_r   <= b_nx;
            f_r   <= f_nx;
            phase <= ph_nx;
            if (step_done) cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/gs_divider_chk.sv
module gs_divider_chk #(
   parameter int FRAC_W  = 16,
   parameter int LAT_MAX = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic [FRAC_W-1:0] dividend,
   input logic [FRAC_W:0]   quotient,
   input logic              done
);
   logic [15:0]       lat_cnt;
   logic [FRAC_W-1:0] dvd_cap;
   logic              armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_cnt <= '0;
         dvd_cap <= '0;
         armed   <= 1'b0;
      end else begin
         if (start && !busy) begin
            lat_cnt <= '0;
            dvd_cap <= dividend;
            armed   <= 1'b1;
         end else begin
            if (busy) lat_cnt <= lat_cnt + 16'd1;
            if (done) armed <= 1'b0;
         end
      end
   end

   // R5: single-cycle completion pulse
   a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5: a completion only follows an accepted request
   a_r5_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> armed);

   // R8: result register moves only together with done
   a_r8_quot_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(quotient) |-> done);

   // R6: a run never outlasts the latency bound
   a_r6_latency_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (lat_cnt < 16'(LAT_MAX)));

   // R3: zero numerator gives zero result
   a_r3_zero_quot: assert property (@(posedge clk) disable iff (!rst_n)
      (done && dvd_cap == '0) |-> (quotient == '0));
endmodule

bind gs_divider gs_divider_chk #(.FRAC_W(FRAC_W), .LAT_MAX(LAT_MAX)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .dividend (dividend),
   .quotient (quotient),
   .done     (done)
);

// File: tb/tb_gs_divider.sv
module tb_gs_divider;
   localparam int CLK_PERIOD = 10;
   localparam int FW         = 16;
   localparam int WAIT_MAX   = 40;
   localparam int LAT_PAR    = 5;
   localparam int LAT_SER    = 9;
   localparam int NVEC       = 10;
   // {dividend, divisor}; expected results are computed below
   localparam logic [31:0] VEC [NVEC] = '{
      32'h4000_8000, 32'h8000_8000, 32'hFFFF_8000, 32'h0001_FFFF,
      32'h1234_C000, 32'hABCD_9F00, 32'h7FFF_FFFF, 32'hFFFF_FFFF,
      32'h5555_AAAA, 32'hE000_F123
   };

   logic          clk   = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [FW-1:0] dvd   = '0;
   logic [FW-1:0] dvs   = 16'h8000;
   logic [FW:0]   q_par, q_ser;
   logic          done_par, done_ser;

   int n_checks = 0;
   int n_errs   = 0;
   int edge_n   = 0;
   int par_cnt  = 0, ser_cnt = 0, par_edge = 0, ser_edge = 0, dbl = 0;
   logic [FW:0] par_q = '0, ser_q = '0;
   logic par_prev = 1'b0, ser_prev = 1'b0;

   gs_divider #(.FRAC_W(FW), .GUARD_W(4), .SEED_W(3), .PAR_MUL(1)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .dividend(dvd),
      .divisor(dvs), .quotient(q_par), .done(done_par));

   gs_divider #(.FRAC_W(FW), .GUARD_W(4), .SEED_W(3), .PAR_MUL(0)) dut_ser (
      .clk(clk), .rst_n(rst_n), .start(start), .dividend(dvd),
      .divisor(dvs), .quotient(q_ser), .done(done_ser));

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) edge_n <= edge_n + 1;

   always @(negedge clk) begin
      if (done_par) begin par_cnt++; par_q = q_par; par_edge = edge_n; end
      if (done_ser) begin ser_cnt++; ser_q = q_ser; ser_edge = edge_n; end
      if ((done_par && par_prev) || (done_ser && ser_prev)) dbl++;
      par_prev = done_par;
      ser_prev = done_ser;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
   endtask

   task automatic issue(input logic [FW-1:0] a, input logic [FW-1:0] b,
                        output int s);
      @(negedge clk);
      dvd = a; dvs = b; start = 1'b1; s = edge_n;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_both(input int p0, input int s0);
      bit ok;
      ok = 1'b0;
      for (int k = 0; k < WAIT_MAX; k++) begin
         @(posedge clk);
         if (par_cnt > p0 && ser_cnt > s0) begin ok = 1'b1; break; end
      end
      check(ok, "R6", "completion within wait window", ok, 1);
   endtask

   task automatic check_q(input string req, input logic [FW-1:0] a,
                          input logic [FW-1:0] b);
      longint e;
      e = (longint'(a) << FW) / longint'(b);
      check(longint'(par_q) >= e - 1 && longint'(par_q) <= e + 1, req,
            "two-multiplier quotient", par_q, e);
      check(longint'(ser_q) >= e - 1 && longint'(ser_q) <= e + 1, req,
            "shared-multiplier quotient", ser_q, e);
   endtask

   task automatic run_one(input string req, input logic [FW-1:0] a,
                          input logic [FW-1:0] b);
      int p0, s0, st;
      p0 = par_cnt; s0 = ser_cnt;
      issue(a, b, st);
      wait_both(p0, s0);
      check_q(req, a, b);
      check(par_edge - st - 1 <= LAT_PAR, "R6", "two-multiplier latency",
            par_edge - st - 1, LAT_PAR);
      check(ser_edge - st - 1 <= LAT_SER, "R6", "shared-multiplier latency",
            ser_edge - st - 1, LAT_SER);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual=expired expected=finished");
      summary();
      $finish;
   end

   initial begin
      int p0, s0, st;
      logic [FW:0] hold_p, hold_s;

      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(done_par == 1'b0, "R1", "done in reset (par)", done_par, 0);
      check(q_par == '0, "R1", "quotient in reset (par)", q_par, 0);
      check(done_ser == 1'b0, "R1", "done in reset (ser)", done_ser, 0);
      check(q_ser == '0, "R1", "quotient in reset (ser)", q_ser, 0);
      rst_n = 1'b1;

      // R2 / R6: vector table
      for (int i = 0; i < NVEC; i++) begin
         run_one("R2", VEC[i][31:16], VEC[i][15:0]);
      end

      // R3: zero dividend
      run_one("R3", 16'h0000, 16'hB000);
      check(par_q == '0, "R3", "exact zero (par)", par_q, 0);
      check(ser_q == '0, "R3", "exact zero (ser)", ser_q, 0);

      // R4: largest ratio, no integer wrap
      p0 = par_cnt; s0 = ser_cnt;
      run_one("R4", 16'hFFFF, 16'h8000);
      check(par_q >= 17'h1FFFD, "R4", "no wrap (par)", par_q, 17'h1FFFE);
      check(ser_q >= 17'h1FFFD, "R4", "no wrap (ser)", ser_q, 17'h1FFFE);

      // R8 / R5: result held, single completion per request
      hold_p = par_q; hold_s = ser_q;
      repeat (10) @(posedge clk);
      @(negedge clk);
      check(q_par == hold_p, "R8", "held quotient (par)", q_par, hold_p);
      check(q_ser == hold_s, "R8", "held quotient (ser)", q_ser, hold_s);
      check(par_cnt == p0 + 1, "R5", "done count (par)", par_cnt, p0 + 1);
      check(ser_cnt == s0 + 1, "R5", "done count (ser)", ser_cnt, s0 + 1);

      // R7: start while busy is ignored
      p0 = par_cnt; s0 = ser_cnt;
      issue(16'h3000, 16'h8000, st);
      @(negedge clk);
      dvd = 16'hF000; dvs = 16'h8000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_both(p0, s0);
      check_q("R7", 16'h3000, 16'h8000);
      repeat (20) @(posedge clk);
      @(negedge clk);
      check(par_cnt == p0 + 1, "R7", "single done (par)", par_cnt, p0 + 1);
      check(ser_cnt == s0 + 1, "R7", "single done (ser)", ser_cnt, s0 + 1);
      check(q_par >= 17'h05FFF && q_par <= 17'h06001, "R7", "live quotient (par)",
            q_par, 17'h06000);
      check(q_ser >= 17'h05FFF && q_ser <= 17'h06001, "R7", "live quotient (ser)",
            q_ser, 17'h06000);

      // R5: done never high two cycles in a row
      check(dbl == 0, "R5", "back-to-back done samples", dbl, 0);

      summary();
      $finish;
   end
endmodule